// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Wait States

This block is the timing controller of a small processor core. Each instruction passes through a decode phase, then an optional middle phase, then a completion phase. The middle phase is used to latch a data-memory address, to apply a relative branch, or to carry out a long jump, a long call or an address-word skip. A wait counter can stretch the completion phase. The sequencer emits one-cycle strobes, and the surrounding datapath uses them to:

- latch an address,
- store an ALU result,
- read or write data memory,
- prefetch the next instruction word,
- step the program counter.

The datapath presents two things each instruction: a decoded class for the latched instruction word, and a 5-bit wait configuration. The low three bits of the configuration set the data-memory wait count. The high two bits set the wait count for instructions that do not touch memory.

At decode, a pending non-maskable interrupt wins over everything else. An enabled maskable request comes next. Otherwise the program counter advances. The ALU, the register file and the trap vector formation all live outside this block.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rstN` is low every strobe output is 0. After release the sequencer passes through a start state that loads the instruction wait count. The first `decodeStb` is high in clock cycle IW+2 after the first rising edge with `rstN` high, where IW = `waitCfg[4:3]`.
- R2: `waitCfg[2:0]` is the data wait field DF and `waitCfg[4:3]` is the instruction wait field IW.
- R3: An instruction of class 0 (none) or class 1 (register) runs IW+2 cycles, counted from its decode cycle to the next decode cycle. Class 1 pulses `storeRes` exactly once. `decodeStb` is never high on two consecutive cycles.
- R4: The data-memory wait count DW is set as follows. When IW = 0, DW = DF. Otherwise DW = max(DF, IW-1). An instruction of class 2 (read) or class 3 (write) runs DW+3 cycles.
- R5: For class 2 or 3, `addrLatch` pulses in the cycle after decode. The completion cycle later pulses `memRead` (class 2) or `memWrite` (class 3), never in the latch cycle.
- R6: No strobe is high during a wait cycle. `prefetch` pulses in every completion cycle. At most one of `storeRes`, `memRead` and `memWrite` is high at a time. Each of them coincides with `prefetch` and is followed by a decode cycle.
- R7: In the decode cycle, a high `nmiPending` gives `takeNmi`. Otherwise `irqRequest` together with `irqEnable` gives `takeIrq`. Otherwise `pcIncr` is given. Exactly one of the three is high. A taken trap ignores `instClass` and runs IW+2 cycles.
- R8: An instruction of class 4 (relative jump) pulses `branchStb` in the cycle after decode and runs IW+3 cycles.
- R9: An instruction of class 5 (conditional long transfer) runs 2·IW+4 cycles with two `prefetch` pulses. The values used are `testPolarity` and `longIsCall` captured at decode, and `testBit` sampled at the first completion. If `testBit` equals `testPolarity`, the block pulses `longCallStb` when `longIsCall` is 1 and `longJump` when it is 0. Otherwise it pulses `skipWord`. At most one of these three strobes is high at a time.
- R10: An instruction of class 6 (unconditional long transfer) behaves like class 5 with the test always matching.
- R11: Class 7 is treated exactly as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instClass | input | 3 | Decoded class of the latched instruction |
| nmiPending | input | 1 | Non-maskable interrupt pending |
| irqRequest | input | 1 | Maskable interrupt request |
| irqEnable | input | 1 | Global maskable interrupt enable |
| waitCfg | input | 5 | Wait configuration: [2:0] data wait, [4:3] instruction wait |
| testBit | input | 1 | Selected register bit for the conditional long transfer |
| testPolarity | input | 1 | Required value of the tested bit |
| longIsCall | input | 1 | Long transfer is a call (1) or a jump (0) |
| decodeStb | output | 1 | Decode cycle |
| pcIncr | output | 1 | Program counter increment at decode |
| takeNmi | output | 1 | Non-maskable trap taken |
| takeIrq | output | 1 | Maskable trap taken |
| addrLatch | output | 1 | Data-memory address latch cycle |
| storeRes | output | 1 | Store register result |
| memRead | output | 1 | Data-memory read completes |
| memWrite | output | 1 | Data-memory write completes |
| prefetch | output | 1 | Fetch next instruction word |
| branchStb | output | 1 | Apply relative branch |
| longJump | output | 1 | Load program counter from address word |
| longCallStb | output | 1 | Push return address and load program counter |
| skipWord | output | 1 | Step program counter past the address word |

## Verification
The bench builds the block with its default field widths: three bits of data wait and two of instruction wait. With these widths all 32 configuration values can be swept for every instruction class, for every tested-bit and polarity combination, and for each interrupt case. That sweep exercises the max(DF, IW-1) selection on both sides of the comparison, the IW = 0 special case, and the longest stretch of seven data waits. For each instruction, the bench checks the decode-to-decode cycle count and the number of pulses on every strobe against closed-form arithmetic.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_REG   = 3'd1,
    CL_RD    = 3'd2,
    CL_WR    = 3'd3,
    CL_JUMP  = 3'd4,
    CL_LCOND = 3'd5,
    CL_LUNC  = 3'd6,
    CL_SPARE = 3'd7
  } instClass_e;

  typedef enum logic [3:0] {
    S_START, S_DECODE, S_ADDR_RD, S_ADDR_WR, S_BRANCH,
    S_LJMP, S_LCALL, S_SKIP,
    S_T2_NEXT, S_T2_STORE, S_T2_READ, S_T2_WRITE, S_T2_ABS
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic loadInst;
    logic loadData;
    logic decr;
  } waitCtl_t;

  // control -> outputs
  typedef struct packed {
    logic decode;
    logic pcIncr;
    logic takeNmi;
    logic takeIrq;
    logic addrLatch;
    logic store;
    logic rd;
    logic wr;
    logic prefetch;
    logic branch;
    logic ljmp;
    logic lcall;
    logic skip;
  } seqStrobes_t;

endpackage

// File: rtl/seq_waitpath.sv
module seq_waitpath
  import seq_pkg::*;
#(
  parameter int DATA_WAIT_W = 3,
  parameter int INST_WAIT_W = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [DATA_WAIT_W+INST_WAIT_W-1:0] waitCfg,
  input  waitCtl_t                           ctl,
  output logic                               waitZero
);

  localparam int CNT_W = (DATA_WAIT_W > INST_WAIT_W) ? DATA_WAIT_W : INST_WAIT_W;

  logic [INST_WAIT_W-1:0] instField;
  logic [DATA_WAIT_W-1:0] dataField;
  logic [CNT_W-1:0]       instWait;
  logic [CNT_W-1:0]       dataExt;
  logic [CNT_W-1:0]       instLess;
  logic [CNT_W-1:0]       dataWait;
  logic [CNT_W-1:0]       waitCnt;

  assign instField = waitCfg[DATA_WAIT_W +: INST_WAIT_W];
  assign dataField = waitCfg[DATA_WAIT_W-1:0];
  assign instWait  = CNT_W'(instField);
  assign dataExt   = CNT_W'(dataField);
  assign instLess  = instWait - CNT_W'(1);

  // memory access: larger of data wait and (instruction wait - 1)
  always_comb begin
    if (instField == '0 || dataExt >= instLess) dataWait = dataExt;
    else                                        dataWait = instLess;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          waitCnt <= '0;
    else if (ctl.loadInst)              waitCnt <= instWait;
    else if (ctl.loadData)              waitCnt <= dataWait;
    else if (ctl.decr && waitCnt != '0) waitCnt <= waitCnt - CNT_W'(1);
  end

  assign waitZero = (waitCnt == '0);

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  instClass,
  input  logic        nmiPending,
  input  logic        irqRequest,
  input  logic        irqEnable,
  input  logic        testBit,
  input  logic        testPolarity,
  input  logic        longIsCall,
  input  logic        waitZero,
  output waitCtl_t    ctl,
  output seqStrobes_t stb
);

  seqState_e  state, nextState;
  instClass_e cls;
  logic       heldUncond, heldPol, heldCall;
  logic       capture;

  assign cls = instClass_e'(instClass);

  always_comb begin
    nextState = state;
    ctl       = '0;
    stb       = '0;
    capture   = 1'b0;
    unique case (state)
      S_START: begin
        ctl.loadInst = 1'b1;
        nextState    = S_T2_NEXT;
      end
      S_DECODE: begin
        stb.decode = 1'b1;
        if (nmiPending) begin
          stb.takeNmi  = 1'b1;
          ctl.loadInst = 1'b1;
          nextState    = S_T2_NEXT;
        end else if (irqRequest && irqEnable) begin
          stb.takeIrq  = 1'b1;
          ctl.loadInst = 1'b1;
          nextState    = S_T2_NEXT;
        end else begin
          stb.pcIncr = 1'b1;
          capture    = 1'b1;
          unique case (cls)
            CL_REG:   begin ctl.loadInst = 1'b1; nextState = S_T2_STORE; end
            CL_RD:    nextState = S_ADDR_RD;
            CL_WR:    nextState = S_ADDR_WR;
            CL_JUMP:  nextState = S_BRANCH;
            CL_LCOND,
            CL_LUNC:  begin ctl.loadInst = 1'b1; nextState = S_T2_ABS; end
            default:  begin ctl.loadInst = 1'b1; nextState = S_T2_NEXT; end
          endcase
        end
      end
      S_ADDR_RD: begin
        stb.addrLatch = 1'b1;
        ctl.loadData  = 1'b1;
        nextState     = S_T2_READ;
      end
      S_ADDR_WR: begin
        stb.addrLatch = 1'b1;
        ctl.loadData  = 1'b1;
        nextState     = S_T2_WRITE;
      end
      S_BRANCH: begin
        stb.branch   = 1'b1;
        ctl.loadInst = 1'b1;
        nextState    = S_T2_NEXT;
      end
      S_LJMP: begin
        stb.ljmp     = 1'b1;
        ctl.loadInst = 1'b1;
        nextState    = S_T2_NEXT;
      end
      S_LCALL: begin
        stb.lcall    = 1'b1;
        ctl.loadInst = 1'b1;
        nextState    = S_T2_NEXT;
      end
      S_SKIP: begin
        stb.skip     = 1'b1;
        ctl.loadInst = 1'b1;
        nextState    = S_T2_NEXT;
      end
      S_T2_NEXT, S_T2_STORE, S_T2_READ, S_T2_WRITE, S_T2_ABS: begin
        if (!waitZero) begin
          ctl.decr = 1'b1;
        end else begin
          stb.prefetch = 1'b1;
          nextState    = S_DECODE;
          unique case (state)
            S_T2_STORE: stb.store = 1'b1;
            S_T2_READ:  stb.rd    = 1'b1;
            S_T2_WRITE: stb.wr    = 1'b1;
            S_T2_ABS: begin
              if (heldUncond || testBit == heldPol)
                nextState = heldCall ? S_LCALL : S_LJMP;
              else
                nextState = S_SKIP;
            end
            default: ;
          endcase
        end
      end
      default: nextState = S_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_START;
      heldUncond <= 1'b0;
      heldPol    <= 1'b0;
      heldCall   <= 1'b0;
    end else begin
      state <= nextState;
      if (capture) begin
        heldUncond <= (cls == CL_LUNC);
        heldPol    <= testPolarity;
        heldCall   <= longIsCall;
      end
    end
  end

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int DATA_WAIT_W = 3,
  parameter int INST_WAIT_W = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [2:0]                         instClass,
  input  logic                               nmiPending,
  input  logic                               irqRequest,
  input  logic                               irqEnable,
  input  logic [DATA_WAIT_W+INST_WAIT_W-1:0] waitCfg,
  input  logic                               testBit,
  input  logic                               testPolarity,
  input  logic                               longIsCall,
  output logic                               decodeStb,
  output logic                               pcIncr,
  output logic                               takeNmi,
  output logic                               takeIrq,
  output logic                               addrLatch,
  output logic                               storeRes,
  output logic                               memRead,
  output logic                               memWrite,
  output logic                               prefetch,
  output logic                               branchStb,
  output logic                               longJump,
  output logic                               longCallStb,
  output logic                               skipWord
);

  waitCtl_t    ctl;
  seqStrobes_t stb;
  logic        waitZero;

  seq_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .instClass    (instClass),
    .nmiPending   (nmiPending),
    .irqRequest   (irqRequest),
    .irqEnable    (irqEnable),
    .testBit      (testBit),
    .testPolarity (testPolarity),
    .longIsCall   (longIsCall),
    .waitZero     (waitZero),
    .ctl          (ctl),
    .stb          (stb)
  );

  seq_waitpath #(
    .DATA_WAIT_W (DATA_WAIT_W),
    .INST_WAIT_W (INST_WAIT_W)
  ) u_wait (
    .clk      (clk),
    .rstN     (rstN),
    .waitCfg  (waitCfg),
    .ctl      (ctl),
    .waitZero (waitZero)
  );

  assign decodeStb   = stb.decode;
  assign pcIncr      = stb.pcIncr;
  assign takeNmi     = stb.takeNmi;
  assign takeIrq     = stb.takeIrq;
  assign addrLatch   = stb.addrLatch;
  assign storeRes    = stb.store;
  assign memRead     = stb.rd;
  assign memWrite    = stb.wr;
  assign prefetch    = stb.prefetch;
  assign branchStb   = stb.branch;
  assign longJump    = stb.ljmp;
  assign longCallStb = stb.lcall;
  assign skipWord    = stb.skip;

endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] instClass,
  input logic       nmiPending,
  input logic       irqRequest,
  input logic       irqEnable,
  input logic       decodeStb,
  input logic       pcIncr,
  input logic       takeNmi,
  input logic       takeIrq,
  input logic       addrLatch,
  input logic       storeRes,
  input logic       memRead,
  input logic       memWrite,
  input logic       prefetch,
  input logic       branchStb,
  input logic       longJump,
  input logic       longCallStb,
  input logic       skipWord
);

  logic plainDecode;
  assign plainDecode = decodeStb && !nmiPending && !(irqRequest && irqEnable);

  p_no_double_decode_r3: assert property (@(posedge clk) disable iff (!rstN)
    decodeStb |=> !decodeStb);

  p_mem_latch_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    plainDecode && (instClass == 3'd2 || instClass == 3'd3) |=> addrLatch);

  p_latch_not_final_r5: assert property (@(posedge clk) disable iff (!rstN)
    addrLatch |-> !memRead && !memWrite && !prefetch);

  p_action_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeRes, memRead, memWrite}));

  p_action_prefetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (storeRes || memRead || memWrite) |-> prefetch);

  p_action_then_decode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (storeRes || memRead || memWrite) |=> decodeStb);

  p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    decodeStb && nmiPending |-> takeNmi && !takeIrq && !pcIncr);

  p_decode_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    decodeStb |-> $onehot({takeNmi, takeIrq, pcIncr}));

  p_pc_only_decode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pcIncr || takeNmi || takeIrq) |-> decodeStb);

  p_branch_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    plainDecode && instClass == 3'd4 |=> branchStb);

  p_long_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({longJump, longCallStb, skipWord}));

  always_comb begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (!decodeStb && !prefetch && !storeRes && !addrLatch);
    end
  end

endmodule

bind instr_cycle_seq instr_cycle_seq_chk u_chk (.*);

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] instClass = '0;
  logic       nmiPending = 1'b0, irqRequest = 1'b0, irqEnable = 1'b0;
  logic [4:0] waitCfg = '0;
  logic       testBit = 1'b0, testPolarity = 1'b0, longIsCall = 1'b0;
  logic decodeStb, pcIncr, takeNmi, takeIrq, addrLatch, storeRes, memRead, memWrite;
  logic prefetch, branchStb, longJump, longCallStb, skipWord;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  instr_cycle_seq uut (.*);

  task automatic check(input string tag, input longint act, input longint exp, input string ctx);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, ctx, act, exp);
    end
  endtask

  function automatic string lenTag(input int c);
    case (c)
      1:       return "R3";
      2, 3:    return "R4";
      4:       return "R8";
      5:       return "R9";
      6:       return "R10";
      7:       return "R11";
      default: return "R3";
    endcase
  endfunction

  // Execute one instruction starting at the negedge of its decode cycle.
  task automatic exec(input int cls, input bit nmi, input bit irq, input bit en,
                      input bit tb, input bit pol, input bit call, input int cfg);
    int iw, df, dw, eff, expLen, len;
    int nSt, nRd, nWr, nAl, nPf, nBr, nLj, nLc, nSk;
    int eSt, eRd, eWr, eAl, ePf, eBr, eLj, eLc, eSk;
    bit taken;
    string ctx;
    instClass = 3'(cls); nmiPending = nmi; irqRequest = irq; irqEnable = en;
    testBit = tb; testPolarity = pol; longIsCall = call; waitCfg = 5'(cfg);
    #1;
    ctx = $sformatf("cfg=%0d cls=%0d nmi=%0d irq=%0d en=%0d tb=%0d pol=%0d call=%0d",
                    cfg, cls, nmi, irq, en, tb, pol, call);
    // R7 decode priority
    check("R7", {takeNmi, takeIrq, pcIncr},
          nmi ? 3'b100 : ((irq && en) ? 3'b010 : 3'b001), ctx);
    // R2 field split, R4 data wait selection
    iw = (cfg >> 3) & 3;
    df = cfg & 7;
    dw = (iw == 0) ? df : ((df > iw - 1) ? df : iw - 1);
    eff = (nmi || (irq && en)) ? 0 : cls;
    taken = (eff == 6) || (tb == pol);
    case (eff)
      2, 3:    expLen = dw + 3;
      4:       expLen = iw + 3;
      5, 6:    expLen = 2 * iw + 4;
      default: expLen = iw + 2;
    endcase
    eSt = (eff == 1); eRd = (eff == 2); eWr = (eff == 3);
    eAl = (eff == 2 || eff == 3); eBr = (eff == 4);
    ePf = (eff == 5 || eff == 6) ? 2 : 1;
    eLj = (eff >= 5 && eff <= 6 && taken && !call);
    eLc = (eff >= 5 && eff <= 6 && taken && call);
    eSk = (eff >= 5 && eff <= 6 && !taken);
    nSt = 0; nRd = 0; nWr = 0; nAl = 0; nPf = 0; nBr = 0; nLj = 0; nLc = 0; nSk = 0;
    len = 0;
    forever begin
      nSt += int'(storeRes); nRd += int'(memRead); nWr += int'(memWrite);
      nAl += int'(addrLatch); nPf += int'(prefetch); nBr += int'(branchStb);
      nLj += int'(longJump); nLc += int'(longCallStb); nSk += int'(skipWord);
      @(negedge clk);
      len++;
      if (decodeStb || len > 64) break;
    end
    check(lenTag(eff), len, expLen, {ctx, " cycles"});
    // R5 R6 R8 R9 R10: strobe pulse counts per instruction
    check((eff >= 5 && eff <= 6) ? (eff == 5 ? "R9" : "R10") : (eAl ? "R5" : "R6"),
          {4'(nSt), 4'(nRd), 4'(nWr), 4'(nAl), 4'(nPf), 4'(nBr), 4'(nLj), 4'(nLc), 4'(nSk)},
          {4'(eSt), 4'(eRd), 4'(eWr), 4'(eAl), 4'(ePf), 4'(eBr), 4'(eLj), 4'(eLc), 4'(eSk)},
          {ctx, " strobes"});
  endtask

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    waitCfg = 5'b11_010;
    repeat (3) @(negedge clk);
    // R1 quiet during reset
    check("R1", {decodeStb, pcIncr, addrLatch, storeRes, memRead, memWrite, prefetch,
                 branchStb, longJump, longCallStb, skipWord}, 0, "in reset");
    rstN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!decodeStb && n < 64);
    // R1 start state applies instruction wait (IW=3)
    check("R1", n, 5, "first decode cycle");

    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 8; k++) begin
        if (k == 5 || k == 6) begin
          for (int m = 0; m < 4; m++)
            exec(k, 0, 0, 0, m[0], m[1], m[0] ^ m[1], c);
        end else begin
          exec(k, 0, 0, 0, 0, 0, 0, c);
        end
      end
      exec(2, 1, 1, 1, 0, 0, 0, c);  // R7 NMI wins
      exec(3, 0, 1, 1, 0, 0, 0, c);  // R7 enabled IRQ
      exec(1, 0, 1, 0, 0, 0, 0, c);  // R7 masked IRQ ignored
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule